// File: doc/BRIEF.md
# Counter Snapshot Capture Unit

This block takes a snapshot of an externally supplied 12-bit free-running count whenever a trigger arrives. It holds the snapshot in a capture register that an 8-bit CPU bus can read. There are three trigger sources:

- a rising edge on event input A, or on the comparator input when that input is selected in place of A;
- a rising edge on event input B;
- a software write.

Hardware triggers count only while the enable for their channel is asserted. Each capture records whether it came from software or from hardware.

The CPU reads the 12-bit snapshot over the 8-bit bus in two steps. Reading the low byte returns the low eight bits and copies the high part and the source flag into a byte-wide temporary latch. Reading the high-byte address then returns that latch, so both halves belong to the same snapshot. A mask byte enables a one-cycle interrupt pulse for each hardware channel.

Top module: `evcap_top`

## Requirements
- R1: After reset, the snapshot, the source flag, the temporary latch and both mask bits are 0, and both interrupt outputs are low.
- R2: A bus write to address 1 with data bit 7 set captures `cnt_i` as sampled at that clock edge. The following snapshot read shows the value, with bit 7 of the high byte equal to 1.
- R3: A rising edge on a channel's raw input with that channel's enable high captures `cnt_i` three clock edges after the input rises. The source bit then reads 0. Channel 0 is `ev_a_i`, or `cmp_i` when `sel_cmp_i` is 1. Channel 1 is `ev_b_i`.
- R4: An input edge on a channel whose enable is low leaves the snapshot unchanged and raises no interrupt.
- R5: An input held high causes exactly one capture. Later count changes do not appear in the snapshot until a new rising edge arrives.
- R6: A read of address 0 returns snapshot bits 7:0 and loads the latch with {source, 3'b000, snapshot[11:8]}. A read of address 1 returns the latch, so bits 6:4 of the high byte read 0.
- R7: The latch keeps its value when the snapshot changes between a low-byte read and the following high-byte read.
- R8: Address 2 is the mask byte. Bit 3 enables channel 0 interrupts and bit 4 enables channel 1 interrupts. All other bits read 0 and ignore writes.
- R9: An enabled capture event on a channel whose mask bit is set drives that channel's interrupt output high for exactly one cycle. The pulse comes on the same edge as the capture.
- R10: When a software trigger and a hardware capture land on the same edge, the source bit reads 1.
- R11: With `sel_cmp_i` at 1, a rising edge on `cmp_i` captures on channel 0 and an edge on `ev_a_i` does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 12 | Free-running count to be captured |
| ev_a_i | input | 1 | Asynchronous event input, channel 0 |
| ev_b_i | input | 1 | Asynchronous event input, channel 1 |
| cmp_i | input | 1 | Comparator output, alternative channel 0 source |
| sel_cmp_i | input | 1 | 1 selects cmp_i as the channel 0 source |
| cap_en_a_i | input | 1 | Capture enable, channel 0 |
| cap_en_b_i | input | 1 | Capture enable, channel 1 |
| bus_addr_i | input | 2 | Register address: 0 low byte, 1 high byte, 2 mask |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational from the address) |
| irq_a_o | output | 1 | Interrupt pulse, channel 0 |
| irq_b_o | output | 1 | Interrupt pulse, channel 1 |

## Verification
Capture is driven in turn by software writes, by channel 0 edges from the event pin, by channel 0 edges from the comparator, and by channel 1 edges. Each is tried with different count values, so a source mix-up shows in the flag bit, the data, or the interrupt line that fires. Further cases separate a held level from a fresh edge and an enabled channel from a disabled one. One case has software and hardware colliding on the same edge. Another reads low byte then high byte around an intervening capture, which separates a latched high byte from a live one.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
    localparam int CNT_W   = 12;
    localparam int DATA_W  = 8;
    localparam int HI_W    = CNT_W - DATA_W;
    localparam int PAD_W   = DATA_W - 1 - HI_W;
    localparam int N_CH    = 2;
    localparam int SYNC_N  = 2;

    localparam logic [1:0] ADDR_LO  = 2'd0;
    localparam logic [1:0] ADDR_HI  = 2'd1;
    localparam logic [1:0] ADDR_MSK = 2'd2;

    localparam int SW_BIT    = 7;
    localparam int MSK_A_BIT = 3;
    localparam int MSK_B_BIT = 4;

    typedef struct packed {
        logic [CNT_W-1:0]  cap;
        logic              src_sw;
        logic [DATA_W-1:0] tmp;
        logic [N_CH-1:0]   mask;
        logic [N_CH-1:0]   irq;
    } rf_state_t;
endpackage

// File: rtl/evcap_sync_edge.sv
module evcap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES:0] pipe;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.pipe[STAGES-1] & ~st_q.pipe[STAGES];
endmodule

// File: rtl/evcap_regs.sv
module evcap_regs
    import evcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [N_CH-1:0]   hw_ev_i,
    input  logic [1:0]        bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [N_CH-1:0]   irq_o,
    output logic [CNT_W-1:0]  cap_o,
    output logic              src_o,
    output logic [N_CH-1:0]   mask_o
);
    rf_state_t st_d, st_q;
    logic      sw_trig;

    assign sw_trig = bus_wr_i && (bus_addr_i == ADDR_HI) && bus_wdata_i[SW_BIT];

    always_comb begin
        st_d     = st_q;
        st_d.irq = hw_ev_i & st_q.mask;

        // Software has priority over a hardware event on the same edge.
        if (sw_trig) begin
            st_d.cap    = cnt_i;
            st_d.src_sw = 1'b1;
        end else if (|hw_ev_i) begin
            st_d.cap    = cnt_i;
            st_d.src_sw = 1'b0;
        end

        if (bus_wr_i && (bus_addr_i == ADDR_MSK)) begin
            st_d.mask[0] = bus_wdata_i[MSK_A_BIT];
            st_d.mask[1] = bus_wdata_i[MSK_B_BIT];
        end

        // Low-byte read freezes the matching high part for the next access.
        if (bus_rd_i && (bus_addr_i == ADDR_LO))
            st_d.tmp = {st_q.src_sw, {PAD_W{1'b0}}, st_q.cap[CNT_W-1:DATA_W]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            ADDR_LO:  bus_rdata_o = st_q.cap[DATA_W-1:0];
            ADDR_HI:  bus_rdata_o = st_q.tmp;
            ADDR_MSK: begin
                bus_rdata_o[MSK_A_BIT] = st_q.mask[0];
                bus_rdata_o[MSK_B_BIT] = st_q.mask[1];
            end
            default:  bus_rdata_o = '0;
        endcase
    end

    assign irq_o  = st_q.irq;
    assign cap_o  = st_q.cap;
    assign src_o  = st_q.src_sw;
    assign mask_o = st_q.mask;
endmodule

// File: rtl/evcap_top.sv
module evcap_top
    import evcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              ev_a_i,
    input  logic              ev_b_i,
    input  logic              cmp_i,
    input  logic              sel_cmp_i,
    input  logic              cap_en_a_i,
    input  logic              cap_en_b_i,
    input  logic [1:0]        bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_a_o,
    output logic              irq_b_o
);
    logic [N_CH-1:0]  raw_ev;
    logic [N_CH-1:0]  ch_en;
    logic [N_CH-1:0]  ch_rise;
    logic [N_CH-1:0]  hw_ev;
    logic [N_CH-1:0]  irq_vec;
    logic [N_CH-1:0]  mask_bits;
    logic [CNT_W-1:0] cap_val;
    logic             cap_src;

    assign raw_ev[0] = sel_cmp_i ? cmp_i : ev_a_i;
    assign raw_ev[1] = ev_b_i;
    assign ch_en     = {cap_en_b_i, cap_en_a_i};

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        evcap_sync_edge #(.STAGES(SYNC_N)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (raw_ev[g]),
            .rise_o  (ch_rise[g])
        );
        assign hw_ev[g] = ch_rise[g] & ch_en[g];
    end

    evcap_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_i       (cnt_i),
        .hw_ev_i     (hw_ev),
        .bus_addr_i  (bus_addr_i),
        .bus_wr_i    (bus_wr_i),
        .bus_rd_i    (bus_rd_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_vec),
        .cap_o       (cap_val),
        .src_o       (cap_src),
        .mask_o      (mask_bits)
    );

    assign irq_a_o = irq_vec[0];
    assign irq_b_o = irq_vec[1];
endmodule

// File: rtl/evcap_checker.sv
module evcap_checker
    import evcap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  cnt_i,
    input logic [1:0]        bus_addr_i,
    input logic              bus_wr_i,
    input logic              bus_rd_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic              irq_a_o,
    input logic              irq_b_o,
    input logic [N_CH-1:0]   hw_ev,
    input logic [N_CH-1:0]   mask_bits,
    input logic [CNT_W-1:0]  cap_val,
    input logic              cap_src
);
    p_sw_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == ADDR_HI && bus_wdata_i[SW_BIT])
        |=> (cap_src && cap_val == $past(cnt_i)));

    p_no_spurious_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_wr_i && bus_addr_i == ADDR_HI && bus_wdata_i[SW_BIT]) && hw_ev == '0)
        |=> $stable(cap_val));

    p_hi_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == ADDR_HI) |-> (bus_rdata_o[6:4] == 3'b000));

    p_mask_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == ADDR_MSK) |-> (bus_rdata_o[7:5] == 3'b000 && bus_rdata_o[2:0] == 3'b000));

    p_irq_a_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a_o |=> !irq_a_o);

    p_irq_b_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_b_o |=> !irq_b_o);

    p_irq_a_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_a_o) |-> ($past(hw_ev[0]) && $past(mask_bits[0])));

    p_irq_b_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_b_o) |-> ($past(hw_ev[1]) && $past(mask_bits[1])));
endmodule

bind evcap_top evcap_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_i       (cnt_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_a_o     (irq_a_o),
    .irq_b_o     (irq_b_o),
    .hw_ev       (hw_ev),
    .mask_bits   (mask_bits),
    .cap_val     (cap_val),
    .cap_src     (cap_src)
);

// File: tb/test_evcap_top.sv
module test_evcap_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cnt_i = '0;
    logic        ev_a_i = 1'b0, ev_b_i = 1'b0, cmp_i = 1'b0, sel_cmp_i = 1'b0;
    logic        cap_en_a_i = 1'b0, cap_en_b_i = 1'b0;
    logic [1:0]  bus_addr_i = '0;
    logic        bus_wr_i = 1'b0, bus_rd_i = 1'b0;
    logic [7:0]  bus_wdata_i = '0;
    logic [7:0]  bus_rdata_o;
    logic        irq_a_o, irq_b_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    evcap_top i_evcap_top (.*);

    // src: 0 software, 1 channel A pin, 2 channel B pin, 3 comparator
    typedef struct packed {
        logic [11:0] cnt;
        logic [1:0]  src;
        logic [7:0]  exp_lo;
        logic [7:0]  exp_hi;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{12'h5A3, 2'd0, 8'hA3, 8'h85},
        '{12'h0F1, 2'd1, 8'hF1, 8'h00},
        '{12'hC3E, 2'd2, 8'h3E, 8'h0C},
        '{12'h7FF, 2'd3, 8'hFF, 8'h07},
        '{12'hFFF, 2'd0, 8'hFF, 8'h8F},
        '{12'h801, 2'd2, 8'h01, 8'h08}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
        @(negedge clk);
        bus_wr_i = 1'b0; bus_wdata_i = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr_i = a; bus_rd_i = 1'b1;
        #1 d = bus_rdata_o;
        @(negedge clk);
        bus_rd_i = 1'b0;
    endtask

    task automatic read_cap(output logic [7:0] lo, output logic [7:0] hi);
        bus_read(2'd0, lo);
        bus_read(2'd1, hi);
    endtask

    // Raise a raw input at a negedge; capture lands on the third posedge.
    task automatic hw_pulse(input int which, input logic exp_a, input logic exp_b, input string req);
        @(negedge clk);
        case (which)
            1: ev_a_i = 1'b1;
            2: ev_b_i = 1'b1;
            default: cmp_i = 1'b1;
        endcase
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({req, " irq_a pulse"}, irq_a_o, exp_a);
        check({req, " irq_b pulse"}, irq_b_o, exp_b);
        ev_a_i = 1'b0; ev_b_i = 1'b0; cmp_i = 1'b0;
        @(negedge clk);
        check({req, " irq_a one cycle"}, irq_a_o, 1'b0);
        check({req, " irq_b one cycle"}, irq_b_o, 1'b0);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] lo, hi, m;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        read_cap(lo, hi);
        check("R1 low byte", lo, 8'h00);
        check("R1 high byte", hi, 8'h00);
        bus_read(2'd2, m);
        check("R1 mask", m, 8'h00);
        check("R1 irq", {irq_a_o, irq_b_o}, 2'b00);

        // R8: mask reserved bits
        bus_write(2'd2, 8'hFF);
        bus_read(2'd2, m);
        check("R8 mask readback", m, 8'h18);

        cap_en_a_i = 1'b1; cap_en_b_i = 1'b1;
        for (int i = 0; i < 6; i++) begin
            cnt_i = VECS[i].cnt;
            sel_cmp_i = (VECS[i].src == 2'd3);
            @(negedge clk);
            case (VECS[i].src)
                2'd0: bus_write(2'd1, 8'h80);
                2'd1: hw_pulse(1, 1'b1, 1'b0, "R3/R9 chA");
                2'd2: hw_pulse(2, 1'b0, 1'b1, "R3/R9 chB");
                default: hw_pulse(3, 1'b1, 1'b0, "R11/R9 cmp");
            endcase
            read_cap(lo, hi);
            check("R2/R3/R6 vec low", lo, VECS[i].exp_lo);
            check("R2/R3/R6 vec high", hi, VECS[i].exp_hi);
        end
        sel_cmp_i = 1'b0;

        // R11: with comparator selected, the A pin is ignored
        @(negedge clk);
        sel_cmp_i = 1'b1;
        cnt_i = 12'h123;
        hw_pulse(1, 1'b0, 1'b0, "R11 pin ignored");
        read_cap(lo, hi);
        check("R11 unchanged low", lo, 8'h01);
        sel_cmp_i = 1'b0;

        // R4: disabled channel
        cap_en_a_i = 1'b0;
        cnt_i = 12'h456;
        hw_pulse(1, 1'b0, 1'b0, "R4 disabled");
        read_cap(lo, hi);
        check("R4 low unchanged", lo, 8'h01);
        check("R4 high unchanged", hi, 8'h08);
        cap_en_a_i = 1'b1;

        // R9: mask cleared -> capture but no irq
        bus_write(2'd2, 8'h00);
        cnt_i = 12'h2B7;
        hw_pulse(2, 1'b0, 1'b0, "R9 masked");
        read_cap(lo, hi);
        check("R9 masked capture low", lo, 8'hB7);

        // R5: held level captures once
        @(negedge clk);
        cnt_i = 12'h3C4;
        ev_b_i = 1'b1;
        repeat (6) @(negedge clk);
        cnt_i = 12'h9D2;
        repeat (6) @(negedge clk);
        read_cap(lo, hi);
        check("R5 single capture low", lo, 8'hC4);
        check("R5 single capture high", hi, 8'h03);
        ev_b_i = 1'b0;
        repeat (4) @(negedge clk);

        // R7: latch holds across an intervening capture
        cnt_i = 12'hA5C;
        bus_write(2'd1, 8'h80);
        bus_read(2'd0, lo);
        cnt_i = 12'h1FF;
        bus_write(2'd1, 8'h80);
        bus_read(2'd1, hi);
        check("R7 latched high", hi, 8'h8A);
        check("R7 latched low", lo, 8'h5C);
        read_cap(lo, hi);
        check("R7 fresh high", hi, 8'h81);

        // R2: write without bit 7 does not capture
        cnt_i = 12'h777;
        bus_write(2'd1, 8'h7F);
        read_cap(lo, hi);
        check("R2 no trigger low", lo, 8'hFF);

        // R10: software and hardware on the same edge
        cnt_i = 12'h640;
        hw_pulse(1, 1'b0, 1'b0, "R10 setup");
        read_cap(lo, hi);
        check("R10 setup source hw", hi, 8'h06);
        cnt_i = 12'h2E5;
        @(negedge clk);
        ev_a_i = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        bus_addr_i = 2'd1; bus_wdata_i = 8'h80; bus_wr_i = 1'b1;
        @(negedge clk);
        bus_wr_i = 1'b0; bus_wdata_i = '0; ev_a_i = 1'b0;
        repeat (3) @(negedge clk);
        read_cap(lo, hi);
        check("R10 software wins", hi, 8'h82);
        check("R10 value", lo, 8'hE5);

        finish_run();
    end
endmodule